// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block runs one high-speed DMA channel. Software sets it up through a small register write and read port: a 28-bit source address, a 28-bit destination address, a shared 24-bit counter word, a transfer mode, a separate address-update rule for each address, the choice between two-address and one-address transfers, a direction bit, an enable bit and a trigger-pending flag. A one-cycle pulse on the `trig` input marks a trigger as pending. The channel then issues bus requests, and it steps its addresses and counter after each unit it moves.

A unit is one read at the source followed by one write at the destination when the channel is in dual-address mode. In single-address mode a unit is one access at the source address, and the direction bit sets whether it reads or writes. When the counter reaches zero, the channel clears its own enable, raises `done` for one cycle, and stays idle until software enables it again.

The counter word changes meaning with the mode. Single and successive transfers use all 24 bits as one unit count. Block transfers split the word: the low 8 bits hold the block length and the upper 16 bits count blocks.

Top module: `dma_chan_seq`

## Requirements
- R1: Register map on `cfg_addr`:
  - 0: source address bits [15:0].
  - 1: source address bits [27:16] in bits [11:0], source update rule in bits [13:12].
  - 2: destination address bits [15:0].
  - 3: destination address bits [27:16] in bits [11:0], destination update rule in bits [13:12], transfer mode in bits [15:14].
  - 4: counter word bits [15:0].
  - 5: counter word bits [23:16] in bits [7:0], direction in bit 14, dual-address in bit 15.
  - 6: enable in bit 0.
  - 7: trigger flag in bit 0.
  
  Every register reads back through `cfg_rdata`. A `trig` pulse sets the flag. Writing 1 to the flag clears it, and writing 0 leaves it unchanged.
- R2: Transfer mode 11 is invalid. With this mode the channel never issues a request, and a pending trigger stays pending.
- R3: Transfer mode 00 (single) moves one unit per trigger and decrements the 24-bit counter by one.
- R4: Transfer mode 01 (successive) moves units on a single trigger until the 24-bit counter reaches zero.
- R5: Transfer mode 10 (block) moves the number of units given by the block length (counter word bits [7:0]) per trigger. It decrements the block count (counter word bits [23:8]) once per block.
- R6: Update rule encoding, applied after each unit:
  - 00: the address is fixed.
  - 01: the address decrements by one.
  - 11: the address increments by one.
  - 10: the address increments by one. In block mode, at the end of each block, it also returns to the value it held when the channel was enabled.
- R7: In dual-address mode each unit reads at the source address and then writes the data just read to the destination address.
- R8: In single-address mode each unit is one access at the source address, with `bus_we` equal to the direction bit. The destination address stays unchanged.
- R9: When the count reaches zero, the channel clears its enable and pulses `done` high for exactly one cycle. It then ignores triggers until it is re-enabled.
- R10: A bus request keeps its address and write strobe unchanged until `bus_rdy` is sampled high.
- R11: After reset the enable is 0, the trigger flag is 0 and no request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for `cfg_addr` |
| trig | input | 1 | Trigger pulse |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write access, 0 for a read access |
| bus_addr | output | 28 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_rdy` |
| bus_rdy | input | 1 | Access complete |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that:
- a request holds its address and strobe while it waits for ready;
- an invalid mode never starts;
- `done` lasts one cycle and always comes with a cleared enable;
- a disabled channel requests nothing;
- every completed dual-mode read is followed at once by a write.

Only the bench's sweeps can show the rest. It runs every mode against every pair of update rules, in both address modes and both directions, and compares each access address, each write data value, the counter value after each trigger, the final addresses and the number of accesses with values computed arithmetically.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 28,
  parameter int DW = 16,
  parameter int CW = 24,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          trig,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          done
);
  localparam int HW = AW - DW;
  localparam int CH = CW - DW;
  localparam int NB = CW - BW;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;
  st_t st;

  logic [AW-1:0] src, dst, src0, dst0;
  logic [1:0]    sctl, dctl, mode;
  logic [CW-1:0] cnt;
  logic [BW-1:0] left;
  logic [DW-1:0] buf_q;
  logic          dual, dir, en, flag;

  wire blk      = mode == 2'b10;
  wire cnt_zero = blk ? (cnt[CW-1:BW] == '0) : (cnt == '0);
  wire go       = st == S_IDLE && en && flag && mode != 2'b11 && !cnt_zero;
  wire acc      = bus_req && bus_rdy;
  wire blk_end  = blk && left == BW'(1);
  wire last     = blk ? (cnt[CW-1:BW] == NB'(1)) : (cnt == CW'(1));
  wire fin      = (!blk || blk_end) && last;
  wire stop     = mode == 2'b00 || blk_end || fin;
  wire [CW-1:0] dec = blk ? (CW'(1) << BW) : CW'(1);

  assign bus_req   = st != S_IDLE;
  assign bus_we    = (st == S_WR) || (st == S_RD && !dual && dir);
  assign bus_addr  = (st == S_WR) ? dst : src;
  assign bus_wdata = buf_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a, input logic [1:0] c,
                                        input logic [AW-1:0] a0, input logic back);
    case (c)
      2'b00:   nxt = a;
      2'b01:   nxt = a - AW'(1);
      2'b10:   nxt = back ? a0 : a + AW'(1);
      default: nxt = a + AW'(1);
    endcase
  endfunction

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = src[DW-1:0];
      3'd1:    cfg_rdata = {{(DW-HW-2){1'b0}}, sctl, src[AW-1:DW]};
      3'd2:    cfg_rdata = dst[DW-1:0];
      3'd3:    cfg_rdata = {mode, dctl, dst[AW-1:DW]};
      3'd4:    cfg_rdata = cnt[DW-1:0];
      3'd5:    cfg_rdata = {dual, dir, {(DW-CH-2){1'b0}}, cnt[CW-1:DW]};
      3'd6:    cfg_rdata = {{(DW-1){1'b0}}, en};
      default: cfg_rdata = {{(DW-1){1'b0}}, flag};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      src <= '0; dst <= '0; src0 <= '0; dst0 <= '0;
      sctl <= '0; dctl <= '0; mode <= '0;
      cnt <= '0; left <= '0; buf_q <= '0;
      dual <= 1'b0; dir <= 1'b0; en <= 1'b0; flag <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (cfg_we) begin
        case (cfg_addr)
          3'd0: src[DW-1:0] <= cfg_wdata;
          3'd1: begin src[AW-1:DW] <= cfg_wdata[HW-1:0]; sctl <= cfg_wdata[HW+1:HW]; end
          3'd2: dst[DW-1:0] <= cfg_wdata;
          3'd3: begin
            dst[AW-1:DW] <= cfg_wdata[HW-1:0];
            dctl <= cfg_wdata[HW+1:HW];
            mode <= cfg_wdata[DW-1:DW-2];
          end
          3'd4: cnt[DW-1:0] <= cfg_wdata;
          3'd5: begin cnt[CW-1:DW] <= cfg_wdata[CH-1:0]; dir <= cfg_wdata[DW-2]; dual <= cfg_wdata[DW-1]; end
          3'd6: begin
            en <= cfg_wdata[0];
            if (cfg_wdata[0] && !en) begin src0 <= src; dst0 <= dst; end
            if (!cfg_wdata[0]) st <= S_IDLE;
          end
          default: if (cfg_wdata[0]) flag <= 1'b0;
        endcase
      end
      if (go) begin
        flag <= 1'b0;
        left <= cnt[BW-1:0];
        st   <= S_RD;
      end
      if (trig) flag <= 1'b1;
      if (acc) begin
        if (st == S_RD) buf_q <= bus_rdata;
        if (st == S_RD && dual) st <= S_WR;
        else begin
          src  <= nxt(src, sctl, src0, blk_end);
          if (dual) dst <= nxt(dst, dctl, dst0, blk_end);
          left <= left - BW'(1);
          if (!blk || blk_end) cnt <= cnt - dec;
          st <= stop ? S_IDLE : S_RD;
          if (fin) begin en <= 1'b0; done <= 1'b1; end
        end
      end
    end
  end
endmodule

module dma_chan_seq_chk #(
  parameter int AW = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_rdy,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          done,
  input logic          en,
  input logic [1:0]    mode,
  input logic          dual
);
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_rdy |=> bus_req && $stable(bus_addr) && $stable(bus_we));
  p_no_start_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && mode == 2'b11 |=> !bus_req);
  p_done_clears_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !en);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !bus_req);
  p_write_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dual && bus_req && bus_rdy && !bus_we |=> bus_req && bus_we);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_rdy(bus_rdy), .bus_we(bus_we),
  .bus_addr(bus_addr), .done(done), .en(en), .mode(mode), .dual(dual)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_NS = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, trig = 1'b0, bus_rdy = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0, bus_rdata = '0, cfg_rdata, bus_wdata;
  logic bus_req, bus_we, done;
  logic [27:0] bus_addr;

  dma_chan_seq u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .trig(trig), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .done(done)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0, fails = 0, acc_n = 0, n_done = 0, wcnt = 0;
  bit inacc = 0;
  logic [27:0] held_addr;
  logic [27:0] ea [64];
  bit          ew [64];
  bit          edc[64];
  logic [15:0] ed [64];

  function automatic logic [15:0] pat(input logic [27:0] a);
    return a[15:0] ^ 16'h5A3C ^ {4'h0, a[27:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (done) n_done++;
    if (bus_rdy) begin
      bus_rdy = 1'b0;
      inacc = 0;
    end else if (bus_req) begin
      if (!inacc) begin
        inacc = 1;
        held_addr = bus_addr;
        wcnt = acc_n % 3;
        if (acc_n < 64) begin
          chk(bus_addr == ea[acc_n], "R6", "access address", {4'h0, bus_addr}, {4'h0, ea[acc_n]});
          chk(bus_we == ew[acc_n], "R8", "access strobe", {31'h0, bus_we}, {31'h0, ew[acc_n]});
          if (edc[acc_n])
            chk(bus_wdata == ed[acc_n], "R7", "write data", {16'h0, bus_wdata}, {16'h0, ed[acc_n]});
        end
        acc_n++;
      end else begin
        chk(bus_addr == held_addr, "R10", "held address", {4'h0, bus_addr}, {4'h0, held_addr});
      end
      if (wcnt == 0) begin
        bus_rdy = 1'b1;
        bus_rdata = pat(bus_addr);
      end else wcnt--;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic pulse;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic wait_idle(input int target);
    int n = 0;
    while ((acc_n < target || bus_req) && n < 1000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic int stepv(input logic [1:0] c);
    return c == 2'b00 ? 0 : (c == 2'b01 ? -1 : 1);
  endfunction

  task automatic run_case(input logic [1:0] mode, input logic [1:0] sc, input logic [1:0] dc,
                          input bit dual, input bit dir);
    logic [27:0] s = 28'h120FFFE, d = 28'h0A00001, sa, da, fs, fd;
    logic [23:0] cw;
    logic [15:0] r, r2;
    int units, per, ntrig, apt, blen;
    bit blk = mode == 2'b10;
    blen = 3;
    cw = mode == 2'b00 ? 24'd3 : (mode == 2'b01 ? 24'd5 : {16'd2, 8'd3});
    units = mode == 2'b00 ? 3 : (mode == 2'b01 ? 5 : 6);
    ntrig = mode == 2'b01 ? 1 : (mode == 2'b00 ? 3 : 2);
    per = units / ntrig;
    apt = per * (dual ? 2 : 1);
    for (int i = 0; i < 64; i++) edc[i] = 0;
    for (int g = 0; g < units; g++) begin
      int k = g % blen;
      sa = s + 28'(stepv(sc) * ((blk && sc == 2'b10) ? k : g));
      da = d + 28'(stepv(dc) * ((blk && dc == 2'b10) ? k : g));
      if (dual) begin
        ea[2*g] = sa; ew[2*g] = 0;
        ea[2*g+1] = da; ew[2*g+1] = 1; ed[2*g+1] = pat(sa); edc[2*g+1] = 1;
      end else begin
        ea[g] = sa; ew[g] = dir;
      end
    end
    wr(3'd0, s[15:0]);
    wr(3'd1, {2'b00, sc, s[27:16]});
    wr(3'd2, d[15:0]);
    wr(3'd3, {mode, dc, d[27:16]});
    wr(3'd4, cw[15:0]);
    wr(3'd5, {dual, dir, 6'h0, cw[23:16]});
    wr(3'd7, 16'h1);
    acc_n = 0; n_done = 0;
    wr(3'd6, 16'h1);
    for (int t = 0; t < ntrig; t++) begin
      logic [23:0] rem;
      pulse();
      wait_idle((t + 1) * apt);
      chk(acc_n == (t + 1) * apt, mode == 2'b10 ? "R5" : (mode == 2'b01 ? "R4" : "R3"),
          "accesses after trigger", acc_n, (t + 1) * apt);
      rem = blk ? {16'(2 - t - 1), 8'd3} : 24'(units - (t + 1) * per);
      rd(3'd4, r); rd(3'd5, r2);
      chk({r2[7:0], r} == rem, blk ? "R5" : "R3", "counter word", {r2[7:0], r}, rem);
    end
    chk(n_done == 1, "R9", "done pulses", n_done, 1);
    rd(3'd6, r);
    chk(r[0] == 1'b0, "R9", "enable after finish", r, 0);
    fs = (sc == 2'b00 || (blk && sc == 2'b10)) ? s : s + 28'(stepv(sc) * units);
    fd = (!dual || dc == 2'b00 || (blk && dc == 2'b10)) ? d : d + 28'(stepv(dc) * units);
    rd(3'd0, r); rd(3'd1, r2);
    chk({r2[11:0], r} == fs, "R6", "final source", {r2[11:0], r}, fs);
    rd(3'd2, r); rd(3'd3, r2);
    chk({r2[11:0], r} == fd, dual ? "R6" : "R8", "final destination", {r2[11:0], r}, fd);
    pulse();
    repeat (10) @(negedge clk);
    chk(acc_n == units * (dual ? 2 : 1), "R9", "accesses after extra trigger", acc_n, units * (dual ? 2 : 1));
    rd(3'd7, r);
    chk(r[0] == 1'b1, "R1", "flag pending", r, 1);
    wr(3'd7, 16'h0); rd(3'd7, r);
    chk(r[0] == 1'b1, "R1", "flag after writing 0", r, 1);
    wr(3'd7, 16'h1); rd(3'd7, r);
    chk(r[0] == 1'b0, "R1", "flag after writing 1", r, 0);
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, "R11", "request in reset", bus_req, 0);
    rst_n = 1'b1;
    rd(3'd6, r); chk(r[0] == 1'b0, "R11", "enable after reset", r, 0);
    rd(3'd7, r); chk(r[0] == 1'b0, "R11", "flag after reset", r, 0);
    chk(bus_req == 1'b0, "R11", "request after reset", bus_req, 0);
    wr(3'd4, 16'hBEEF); rd(3'd4, r);
    chk(r == 16'hBEEF, "R1", "counter low readback", r, 16'hBEEF);
    wr(3'd5, 16'hC012); rd(3'd5, r);
    chk(r == 16'hC012, "R1", "control readback", r, 16'hC012);
    wr(3'd3, {2'b11, 2'b00, 12'h000}); wr(3'd4, 16'h0004); wr(3'd5, 16'h0000);
    wr(3'd7, 16'h1); acc_n = 0;
    wr(3'd6, 16'h1); pulse();
    repeat (20) @(negedge clk);
    chk(acc_n == 0, "R2", "accesses in invalid mode", acc_n, 0);
    rd(3'd7, r); chk(r[0] == 1'b1, "R2", "flag kept in invalid mode", r, 1);
    rd(3'd6, r); chk(r[0] == 1'b1, "R2", "enable kept in invalid mode", r, 1);
    wr(3'd6, 16'h0); wr(3'd7, 16'h1);
    for (int m = 0; m < 3; m++)
      for (int sc = 0; sc < 4; sc++) begin
        for (int dc = 0; dc < 4; dc++) run_case(2'(m), 2'(sc), 2'(dc), 1'b1, 1'b0);
        run_case(2'(m), 2'(sc), 2'(sc ^ 1), 1'b0, 1'b0);
        run_case(2'(m), 2'(sc), 2'(sc ^ 2), 1'b0, 1'b1);
      end
    finish_up();
  end
endmodule